// File: doc/BRIEF.md
# HI/LO Multiply-Divide Accumulator

This unit performs multiplication and division for a 32-bit integer core. Results go to a pair of result registers that together form one 64-bit value: the upper word (HI) and the lower word (LO). It handles plain multiply, multiply-then-add and multiply-then-subtract, each in signed and unsigned forms. It also handles signed and unsigned divide. The core can copy either word out to its register file or load either word from an operand.

A single operation port carries `op_valid`, a 4-bit code and two operands. An operation is taken on a rising edge where `op_valid` is high and `busy` is low. Multiplies run for a fixed `MUL_CYCLES` cycles. Divides run one restoring step per cycle for 32 cycles. Throughout, `busy` stays high, and `done` pulses once the result is written. A request that arrives during a long operation simply waits, because `busy` holds it off. A read of HI or LO therefore returns the freshly written result.

Top module: `hilo_mdu`

## Requirements
- R1: After reset, HI and LO both read as zero, and `busy`, `done` and `rd_valid` are low.
- R2: Code 0 multiplies the operands as signed values and code 1 as unsigned values. The full 64-bit product is written with bits 63:32 in HI and bits 31:0 in LO.
- R3: Code 2 (signed) and code 3 (unsigned) add the 64-bit product of the operands to the current {HI,LO}, modulo 2^64.
- R4: Code 4 (signed) and code 5 (unsigned) subtract the 64-bit product of the operands from the current {HI,LO}, modulo 2^64.
- R5: Code 6 (signed) and code 7 (unsigned) divide `op_a` by `op_b`. The quotient goes to LO and the remainder to HI. Signed quotients truncate toward zero, and the remainder takes the sign of the dividend.
- R6: A divide with a zero divisor takes the normal divide latency and leaves HI and LO unchanged.
- R7: `busy` stays high for exactly `MUL_CYCLES` cycles after a multiply is accepted, and for exactly 32 cycles after a divide. `done` is high for the single cycle in which `busy` has just fallen.
- R8: No operation is accepted while `busy` is high. A read (code 10 for HI, code 11 for LO) held during a busy period is taken after the result is written. `rd_valid` is high in the cycle after acceptance, and `rd_data` then carries the new value.
- R9: Code 8 loads HI from `op_a` and code 9 loads LO from `op_a`. Each leaves the other word unchanged.
- R10: HI and LO do not change while `busy` is high, except at the edge that writes the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 4 | Operation code (see requirements) |
| op_a | input | 32 | First operand / dividend / value to load |
| op_b | input | 32 | Second operand / divisor |
| busy | output | 1 | Long operation in progress; requests are held off |
| done | output | 1 | One-cycle pulse after a multiply or divide result is written |
| rd_valid | output | 1 | `rd_data` holds a HI or LO read |
| rd_data | output | 32 | Read data |

## Verification
Some properties are checked by assertions on every cycle:
- the result registers stay frozen during a busy period;
- a load of one word leaves the other word untouched;
- a zero-divisor completion writes nothing;
- `done` and `rd_valid` only follow a busy cycle, or a non-busy cycle, respectively;
- the divider is never restarted mid-run.

The arithmetic itself can only be shown by the bench's sweeps, which compare against 64-bit reference arithmetic:
- the products;
- accumulation onto seeded HI:LO values;
- signed truncation and the most-negative-over-minus-one case.

The same holds for exact latencies and for a read that stalls across a divide.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
  typedef enum logic [3:0] {
    OP_MUL   = 4'd0,
    OP_MULU  = 4'd1,
    OP_MADD  = 4'd2,
    OP_MADDU = 4'd3,
    OP_MSUB  = 4'd4,
    OP_MSUBU = 4'd5,
    OP_DIV   = 4'd6,
    OP_DIVU  = 4'd7,
    OP_LDHI  = 4'd8,
    OP_LDLO  = 4'd9,
    OP_RDHI  = 4'd10,
    OP_RDLO  = 4'd11
  } mdu_op_e;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_ADD  = 2'd1,
    ACC_SUB  = 2'd2
  } acc_mode_e;
endpackage

// File: rtl/hilo_mac.sv
module hilo_mac
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           sgn,
  input  acc_mode_e      mode,
  input  logic [2*W-1:0] acc,
  output logic [2*W-1:0] res
);
  localparam int DW = 2 * W;

  logic [DW-1:0] ext_a, ext_b, prod;

  always_comb begin
    ext_a = sgn ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    ext_b = sgn ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    prod  = ext_a * ext_b;
    unique case (mode)
      ACC_ADD: res = acc + prod;
      ACC_SUB: res = acc - prod;
      default: res = prod;
    endcase
  end
endmodule

// File: rtl/hilo_divider.sv
module hilo_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         sgn,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic         fin,
  output logic         zero_div,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic          run;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic          negq_q, negr_q, dz_q;

  logic [W:0]    shifted, trial;
  logic          take;
  logic [W-1:0]  rem_n, quo_n;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, dvs_q};
    take    = ~trial[W];
    rem_n   = take ? trial[W-1:0] : shifted[W-1:0];
    quo_n   = {quo_q[W-2:0], take};
  end

  assign fin      = run && (cnt == '0);
  assign zero_div = dz_q;
  assign quo      = negq_q ? -quo_n : quo_n;
  assign rem      = negr_q ? -rem_n : rem_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      cnt    <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      dz_q   <= 1'b0;
    end else if (start) begin
      run    <= 1'b1;
      cnt    <= CW'(W - 1);
      rem_q  <= '0;
      quo_q  <= (sgn && dvd[W-1]) ? -dvd : dvd;
      dvs_q  <= (sgn && dvs[W-1]) ? -dvs : dvs;
      negq_q <= sgn && (dvd[W-1] ^ dvs[W-1]);
      negr_q <= sgn && dvd[W-1];
      dz_q   <= (dvs == '0);
    end else if (run) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      cnt   <= cnt - 1'b1;
      if (cnt == '0) run <= 1'b0;
    end
  end

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !run);
  // R7
  keep_running_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !fin) |=> run);
endmodule

// File: rtl/hilo_mdu.sv
module hilo_mdu
  import hilo_pkg::*;
#(
  parameter int W          = 32,
  parameter int MUL_CYCLES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  localparam int MCW = (MUL_CYCLES > 1) ? $clog2(MUL_CYCLES) : 1;

  logic [W-1:0]   hi_q, lo_q;
  logic           busy_q, done_q, rdv_q;
  logic [W-1:0]   rdd_q;
  logic           mul_run;
  logic [MCW-1:0] mcnt;
  logic [W-1:0]   ma_q, mb_q;
  logic           msgn_q;
  acc_mode_e      mmode_q;

  logic           accept, div_start, div_fin, div_dz, mul_fin, wr_en;
  logic [W-1:0]   div_q, div_r;
  logic [2*W-1:0] mac_res;
  mdu_op_e        op;

  assign op        = mdu_op_e'(op_code);
  assign accept    = op_valid && !busy_q;
  assign div_start = accept && (op == OP_DIV || op == OP_DIVU);
  assign mul_fin   = mul_run && (mcnt == '0);
  assign wr_en     = mul_fin || (div_fin && !div_dz);

  hilo_mac #(.W(W)) u_mac (
    .a(ma_q), .b(mb_q), .sgn(msgn_q), .mode(mmode_q),
    .acc({hi_q, lo_q}), .res(mac_res)
  );

  hilo_divider #(.W(W)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .sgn(op == OP_DIV),
    .dvd(op_a), .dvs(op_b), .fin(div_fin), .zero_div(div_dz),
    .quo(div_q), .rem(div_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      lo_q    <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
      mul_run <= 1'b0;
      mcnt    <= '0;
      ma_q    <= '0;
      mb_q    <= '0;
      msgn_q  <= 1'b0;
      mmode_q <= ACC_NONE;
    end else begin
      done_q <= 1'b0;
      rdv_q  <= 1'b0;
      if (accept) begin
        unique case (op)
          OP_MUL, OP_MULU, OP_MADD, OP_MADDU, OP_MSUB, OP_MSUBU: begin
            busy_q  <= 1'b1;
            mul_run <= 1'b1;
            mcnt    <= MCW'(MUL_CYCLES - 1);
            ma_q    <= op_a;
            mb_q    <= op_b;
            msgn_q  <= (op == OP_MUL) || (op == OP_MADD) || (op == OP_MSUB);
            mmode_q <= (op == OP_MADD || op == OP_MADDU) ? ACC_ADD :
                       (op == OP_MSUB || op == OP_MSUBU) ? ACC_SUB : ACC_NONE;
          end
          OP_DIV, OP_DIVU: busy_q <= 1'b1;
          OP_LDHI: hi_q <= op_a;
          OP_LDLO: lo_q <= op_a;
          OP_RDHI: begin rdv_q <= 1'b1; rdd_q <= hi_q; end
          OP_RDLO: begin rdv_q <= 1'b1; rdd_q <= lo_q; end
          default: ;
        endcase
      end
      if (mul_run) begin
        if (mcnt == '0) begin
          {hi_q, lo_q} <= mac_res;
          mul_run      <= 1'b0;
          busy_q       <= 1'b0;
          done_q       <= 1'b1;
        end else begin
          mcnt <= mcnt - 1'b1;
        end
      end
      if (div_fin) begin
        if (!div_dz) {hi_q, lo_q} <= {div_r, div_q};
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;

  // R10
  frozen_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !wr_en) |=> ($stable(hi_q) && $stable(lo_q)));
  // R9
  ldhi_keeps_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_LDHI) |=> $stable(lo_q));
  // R9
  ldlo_keeps_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_LDLO) |=> $stable(hi_q));
  // R6
  zero_div_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (div_fin && div_dz) |=> ($stable(hi_q) && $stable(lo_q)));
  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));
  // R8
  read_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !$past(busy));
endmodule

// File: tb/hilo_mdu_tb.sv
`timescale 1ns/1ps
module hilo_mdu_tb_top;
  localparam int W = 32;
  localparam int MUL_CYCLES = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic busy, done, rd_valid;
  logic [W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hilo_mdu #(.W(W), .MUL_CYCLES(MUL_CYCLES)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cycles);
      finish_run();
    end
  end

  // drive one op; returns number of busy cycles observed after acceptance
  task automatic do_op(input logic [3:0] c, input logic [W-1:0] a,
                       input logic [W-1:0] b, output int lat);
    @(negedge clk);
    while (busy) @(negedge clk);
    op_valid = 1'b1; op_code = c; op_a = a; op_b = b;
    @(negedge clk);
    op_valid = 1'b0;
    lat = 0;
    while (busy) begin lat++; @(negedge clk); end
  endtask

  task automatic rd(input logic [3:0] c, output logic [W-1:0] d);
    int l;
    do_op(c, '0, '0, l);
    d = rd_data;
    if (!rd_valid) begin
      errors++;
      $display("FAIL R8 actual rd_valid 0 expected 1");
    end
  endtask

  function automatic logic [W-1:0] pick(int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h0000_0003;
      6: return 32'hFFFF_FFF9;
      default: return 32'h1234_5677;
    endcase
  endfunction

  function automatic logic [63:0] ext(logic [W-1:0] v, bit sg);
    return sg ? {{32{v[31]}}, v} : {32'b0, v};
  endfunction

  initial begin
    logic [W-1:0] hi, lo, a, b, d;
    logic [63:0] acc, exp;
    int lat;
    string tag;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 rd_valid", rd_valid, 0);
    rd(4'd10, d); check("R1 hi", d, 0);
    rd(4'd11, d); check("R1 lo", d, 0);

    // R9 loads affect only their own word
    do_op(4'd8, 32'hAAAA_5555, '0, lat);
    rd(4'd11, d); check("R9 lo kept", d, 0);
    rd(4'd10, d); check("R9 hi loaded", d, 32'hAAAA_5555);
    do_op(4'd9, 32'h0F0F_1234, '0, lat);
    rd(4'd10, d); check("R9 hi kept", d, 32'hAAAA_5555);
    rd(4'd11, d); check("R9 lo loaded", d, 32'h0F0F_1234);

    // Sweep all arithmetic codes over operand pairs
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          bit sg;
          a = pick(i); b = pick(j);
          hi = a ^ 32'h5A5A_0F0F ^ (c * 32'h0101);
          lo = b + 32'h8765_4321 + j;
          do_op(4'd8, hi, '0, lat);
          do_op(4'd9, lo, '0, lat);
          acc = {hi, lo};
          sg = (c == 0 || c == 2 || c == 4 || c == 6);
          case (c)
            0, 1: begin exp = ext(a, sg) * ext(b, sg); tag = "R2"; end
            2, 3: begin exp = acc + ext(a, sg) * ext(b, sg); tag = "R3"; end
            4, 5: begin exp = acc - ext(a, sg) * ext(b, sg); tag = "R4"; end
            default: begin
              if (b == 0) begin exp = acc; tag = "R6"; end
              else if (sg) begin
                longint x, y, q, r;
                x = $signed(a); y = $signed(b);
                q = x / y; r = x % y;
                exp = {r[31:0], q[31:0]}; tag = "R5";
              end else begin
                logic [63:0] x, y, q, r;
                x = {32'b0, a}; y = {32'b0, b};
                q = x / y; r = x % y;
                exp = {r[31:0], q[31:0]}; tag = "R5";
              end
            end
          endcase
          do_op(c[3:0], a, b, lat);
          if (i == 0 || c >= 6)
            check("R7 latency", lat, (c >= 6) ? 32 : MUL_CYCLES);
          if (i == 1) check("R7 done pulse", done, 1);
          rd(4'd10, d); check({tag, " hi"}, d, exp[63:32]);
          rd(4'd11, d); check({tag, " lo"}, d, exp[31:0]);
        end
      end
    end

    // R8 a read held across a divide stalls and returns the new quotient
    begin
      bit early;
      early = 0;
      do_op(4'd8, 32'h1111_1111, '0, lat);
      @(negedge clk);
      op_valid = 1'b1; op_code = 4'd7; op_a = 32'd1000; op_b = 32'd7;
      @(negedge clk);
      op_code = 4'd11; op_a = '0; op_b = '0;
      while (!rd_valid) begin
        if (cycles > 140000) break;
        @(negedge clk);
        if (rd_valid && busy) early = 1;
      end
      op_valid = 1'b0;
      check("R8 stalled read data", rd_data, 32'd142);
      check("R8 no read while busy", early, 0);
      @(negedge clk);
      rd(4'd10, d); check("R10 remainder after stall", d, 32'd6);
    end

    finish_run();
  end
endmodule